// File: doc/BRIEF.md
# Phase-Embedded Inversion Encoder

This block turns parallel words into a single serial line and lowers the number of line toggles. Any word that would toggle too often is sent in a recoded form. Every second bit of the word is flipped, counting in transmit order. The block sends no extra flag bit to say that a word was recoded. It marks the choice through timing instead. A recoded word is sent half a bit period late against the forwarded link clock. A word that is sent as-is changes state only on rising edges of that clock. A receiver looks at where the transitions fall inside a word period to recover the choice, then undoes the flips.

The block runs entirely on one fast clock at twice the bit rate. The link clock is that clock divided by two, and a half-bit delay is one fast cycle. Words enter through a valid/ready handshake into a single holding stage, so words can be sent back to back. Each word is sent most significant bit first and takes exactly WL link bit periods, which is 2*WL fast cycles. A frame strobe marks the first bit period of every word. A word that has no transition cannot show a phase. If recoding would produce such a word, the encoder sends the original word aligned instead.

Top module: `phase_inv_enc`

## Requirements
- R1: With STRICT=1, a word is recoded (sent shifted) exactly when its internal transition count Nt (adjacent differing bits, at most WL-1) is greater than WL/2, unless R6 applies.
- R2: Recoding flips every second bit in transmit order: bit i of the word is inverted when WL-1-i is odd (bits WL-2, WL-4, ... down to 0). The bits are sent MSB first. Applying the same flips to a shifted word's received bits gives back the input word.
- R3: No extra bit is sent. Each word takes exactly 2*WL fast cycles, and words sent back to back have frame strobe rises exactly 2*WL fast cycles apart.
- R4: In an aligned word, bit b (counting from the MSB, b=0 first) is on ser_data in fast-cycle slots 2b and 2b+1 of the word. Slot 0 is the first cycle the strobe is high.
- R5: In a shifted word, slot 0 holds the line level of the cycle before the word. Bit b is in slots 2b+1 and 2b+2. The last bit is in slot 2*WL-1 and stays on the line unless an aligned word follows.
- R6: If recoding would produce an all-zero or all-one word, the original word is sent aligned.
- R7: link_clk toggles every fast cycle and is high in even slots. word_start is high in slots 0 and 1 of every word and low otherwise.
- R8: in_ready is high exactly when the holding stage is empty, and it falls in the cycle after an accepted word. A word offered with in_valid low is never sent. Between words, word_start stays low and ser_data holds its level.
- R9: After reset, ser_data and word_start are 0 and in_ready is 1.
- R10: With STRICT=0, a word is recoded when Nt is at least WL/2, unless R6 applies. For WL=4: 1101 is sent as 1000 shifted, 1000 as 1000 aligned, 0100 as 0001 shifted, and 0001 as 0001 aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | WL | Parallel word to send |
| in_valid | input | 1 | in_word holds a word to send |
| in_ready | output | 1 | The holding stage can take a word |
| ser_data | output | 1 | Serial line |
| link_clk | output | 1 | Forwarded link clock, clk divided by two |
| word_start | output | 1 | High during the first bit period of each word |

## Verification
The bench builds two copies of the block. One uses WL=4 with the inclusive threshold and the other uses WL=6 with the strict threshold. Each copy receives every possible input word back to back, then a few spaced words with junk on the data input. This reaches every transition count, both flat-result fallback words in each copy, and the four worked examples at WL=4. Each word is decoded the way a receiver would: the phase is read from where transitions fall and the flips are undone. It is also compared slot by slot against an expected pattern built from the requirements.

// File: rtl/phase_inv_pkg.sv
package phase_inv_pkg;

   // state of the serial line within a word period
   typedef enum logic [1:0] {
      LN_IDLE    = 2'd0,
      LN_ALIGNED = 2'd1,
      LN_SHIFTED = 2'd2
   } pei_mode_e;

endpackage

// File: rtl/phase_inv_decide.sv
// Combinational recoding decision: transition count, threshold, flat guard.
module phase_inv_decide #(
   parameter int WL     = 8,
   parameter bit STRICT = 1'b1
) (
   input  logic [WL-1:0] word_i,
   output logic [WL-1:0] code_o,
   output logic          shift_o
);
   localparam int CW = $clog2(WL);
   localparam logic [CW:0] HALF_C = (CW+1)'(WL/2);

   logic [WL-2:0] edge_v;
   logic [WL-1:0] flip_mask;
   logic [CW:0]   nt;
   logic          over;
   logic [WL-1:0] flipped;
   logic          flat;

   genvar g;
   generate
      for (g = 0; g < WL-1; g++) begin : g_edge
         assign edge_v[g] = word_i[g] ^ word_i[g+1];
      end
      for (g = 0; g < WL; g++) begin : g_mask
         if (((WL-1-g) % 2) == 1) begin : g_flip
            assign flip_mask[g] = 1'b1;
         end else begin : g_keep
            assign flip_mask[g] = 1'b0;
         end
      end
      if (STRICT) begin : g_strict
         assign over = (nt > HALF_C);
      end else begin : g_incl
         assign over = (nt >= HALF_C);
      end
   endgenerate

   always_comb begin
      nt = '0;
      for (int i = 0; i < WL-1; i++) begin
         nt = nt + {{CW{1'b0}}, edge_v[i]};
      end
   end

   assign flipped = word_i ^ flip_mask;
   assign flat    = (flipped == '0) || (flipped == '1);
   assign shift_o = over & ~flat;
   assign code_o  = shift_o ? flipped : word_i;

endmodule

// File: rtl/phase_inv_hold.sv
// Single-entry holding stage between the handshake and the serializer.
module phase_inv_hold #(
   parameter int WL = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [WL-1:0] code_i,
   input  logic          shift_i,
   input  logic          take_i,
   output logic [WL-1:0] code_o,
   output logic          shift_o,
   output logic          valid_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o  <= '0;
         shift_o <= 1'b0;
         valid_o <= 1'b0;
      end else if (load_i && !valid_o) begin
         code_o  <= code_i;
         shift_o <= shift_i;
         valid_o <= 1'b1;
      end else if (take_i) begin
         valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/phase_inv_serial.sv
// Word-period sequencer: link clock, strobe and phase-placed serial data.
module phase_inv_serial
   import phase_inv_pkg::*;
#(
   parameter int WL = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          avail_i,
   input  logic [WL-1:0] code_i,
   input  logic          shift_i,
   output logic          take_o,
   output logic          ser_o,
   output logic          lclk_o,
   output logic          stb_o
);
   localparam int SLOTS = 2*WL;
   localparam int SW    = $clog2(SLOTS);
   localparam logic [SW-1:0] LAST = SW'(SLOTS-1);

   pei_mode_e     mode_q;
   logic [SW-1:0] slot_q;
   logic [WL-1:0] sh_q;
   logic          lclk_q;
   logic          ser_q;
   logic          stb_q;
   logic          boundary;
   logic          load_bit;

   // words start only where the next cycle is a link-clock high half
   assign boundary = !lclk_q && ((mode_q == LN_IDLE) || (slot_q == LAST));
   assign take_o   = boundary && avail_i;
   assign load_bit = (mode_q == LN_ALIGNED) ? slot_q[0] : ~slot_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= LN_IDLE;
         slot_q <= '0;
         sh_q   <= '0;
         lclk_q <= 1'b0;
         ser_q  <= 1'b0;
         stb_q  <= 1'b0;
      end else begin
         lclk_q <= ~lclk_q;
         if (take_o) begin
            slot_q <= '0;
            stb_q  <= 1'b1;
            if (shift_i) begin
               mode_q <= LN_SHIFTED;
               sh_q   <= code_i;
            end else begin
               mode_q <= LN_ALIGNED;
               ser_q  <= code_i[WL-1];
               sh_q   <= code_i << 1;
            end
         end else if (boundary) begin
            mode_q <= LN_IDLE;
            slot_q <= '0;
            stb_q  <= 1'b0;
         end else if (mode_q != LN_IDLE) begin
            slot_q <= slot_q + SW'(1);
            stb_q  <= (slot_q == '0);
            if (load_bit) begin
               ser_q <= sh_q[WL-1];
               sh_q  <= sh_q << 1;
            end
         end
      end
   end

   assign ser_o  = ser_q;
   assign lclk_o = lclk_q;
   assign stb_o  = stb_q;
endmodule

// File: rtl/phase_inv_enc.sv
module phase_inv_enc #(
   parameter int WL     = 8,
   parameter bit STRICT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [WL-1:0] in_word,
   input  logic          in_valid,
   output logic          in_ready,
   output logic          ser_data,
   output logic          link_clk,
   output logic          word_start
);
   generate
      if (WL < 4 || (WL % 2) != 0) begin : g_bad_wl
         $error("phase_inv_enc: WL must be even and at least 4");
      end
   endgenerate

   logic [WL-1:0] code_c;
   logic          shift_c;
   logic [WL-1:0] code_h;
   logic          shift_h;
   logic          hold_v;
   logic          take;

   phase_inv_decide #(.WL(WL), .STRICT(STRICT)) u_dec (
      .word_i  (in_word),
      .code_o  (code_c),
      .shift_o (shift_c)
   );

   phase_inv_hold #(.WL(WL)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (in_valid),
      .code_i  (code_c),
      .shift_i (shift_c),
      .take_i  (take),
      .code_o  (code_h),
      .shift_o (shift_h),
      .valid_o (hold_v)
   );

   assign in_ready = ~hold_v;

   phase_inv_serial #(.WL(WL)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .avail_i (hold_v),
      .code_i  (code_h),
      .shift_i (shift_h),
      .take_o  (take),
      .ser_o   (ser_data),
      .lclk_o  (link_clk),
      .stb_o   (word_start)
   );
endmodule

// File: rtl/phase_inv_enc_chk.sv
module phase_inv_enc_chk #(
   parameter int WL = 8
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic link_clk,
   input logic word_start
);
   localparam int GW = $clog2(2*WL) + 2;

   logic          armed;
   logic          stb_d;
   logic [GW-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         stb_d <= 1'b0;
         gap   <= '1;
      end else begin
         armed <= 1'b1;
         stb_d <= word_start;
         if (word_start && !stb_d) gap <= GW'(1);
         else if (gap != '1)       gap <= gap + GW'(1);
      end
   end

   // R3
   word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_start && !stb_d) |-> (gap >= GW'(2*WL)));

   // R7
   clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      link_clk != $past(link_clk));

   // R7
   strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_start) |-> link_clk);

   // R7
   strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_start) |=> word_start ##1 !word_start);

   // R8
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
endmodule

bind phase_inv_enc phase_inv_enc_chk #(.WL(WL)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .link_clk   (link_clk),
   .word_start (word_start)
);

// File: tb/phase_inv_enc_tb_top.sv
module phase_inv_enc_lane #(
   parameter int WL     = 4,
   parameter bit STRICT = 1'b0
) (
   input logic clk,
   input logic rst_n
);
   localparam int NW = (1 << WL) + 8;
   localparam int SL = 2*WL;

   logic [WL-1:0] in_word;
   logic          in_valid;
   logic          in_ready;
   logic          ser_data;
   logic          link_clk;
   logic          word_start;

   int n_checks = 0;
   int n_errs   = 0;
   int n_sent   = 0;
   int n_done   = 0;
   int n_rise   = 0;
   logic done = 1'b0;
   logic [WL-1:0] sent [NW];
   logic          b2b  [NW];

   phase_inv_enc #(.WL(WL), .STRICT(STRICT)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_word    (in_word),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .ser_data   (ser_data),
      .link_clk   (link_clk),
      .word_start (word_start)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s WL=%0d %s actual=%0h expected=%0h", req, WL, what, act, exp);
      end
   endtask

   function automatic logic [WL-1:0] flips();
      logic [WL-1:0] m;
      for (int i = 0; i < WL; i++) m[i] = (((WL-1-i) % 2) == 1);
      return m;
   endfunction

   task automatic evaluate(input int k, input logic pre, input logic [SL-1:0] cap);
      logic [WL-1:0] w, fl, code, bits, dec;
      logic [SL-1:0] expv;
      int   nt;
      bit   over, flat, exp_sh, det_sh;
      string tag;
      w  = sent[k];
      fl = w ^ flips();
      nt = 0;
      for (int i = 0; i < WL-1; i++) if (w[i] != w[i+1]) nt++;
      over   = STRICT ? (nt > WL/2) : (nt >= WL/2);
      flat   = (fl == '0) || (fl == '1);
      exp_sh = over && !flat;
      code   = exp_sh ? fl : w;
      for (int j = 0; j < SL; j++) begin
         if (!exp_sh)     expv[SL-1-j] = code[WL-1-j/2];
         else if (j == 0) expv[SL-1-j] = pre;
         else             expv[SL-1-j] = code[WL-1-(j-1)/2];
      end
      tag = (over && flat) ? "R6" : (exp_sh ? "R5" : "R4");
      if (WL == 4 && !STRICT && (w == 4'b1101 || w == 4'b1000 || w == 4'b0100 || w == 4'b0001))
         chk(cap == expv, "R10", $sformatf("example word %b slots", w), 64'(cap), 64'(expv));
      else
         chk(cap == expv, tag, $sformatf("word %b slot pattern", w), 64'(cap), 64'(expv));
      // receiver view: phase from transition parity, then undo flips
      det_sh = 1'b0;
      for (int j = 1; j < SL; j++)
         if ((cap[SL-1-j] != cap[SL-j]) && (j % 2 == 1)) det_sh = 1'b1;
      chk(det_sh == exp_sh, STRICT ? "R1" : "R10", $sformatf("word %b phase", w),
          64'(det_sh), 64'(exp_sh));
      for (int b = 0; b < WL; b++) begin
         if (!det_sh)        bits[WL-1-b] = cap[SL-1-(2*b+1)];
         else if (b < WL-1)  bits[WL-1-b] = cap[SL-1-(2*b+2)];
         else                bits[WL-1-b] = cap[0];
      end
      dec = det_sh ? (bits ^ flips()) : bits;
      chk(dec == w, "R2", "decoded word", 64'(dec), 64'(w));
   endtask

   task automatic send(input logic [WL-1:0] w, input bit streaming);
      in_word  = w;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      sent[n_sent] = w;
      b2b[n_sent]  = streaming;
      n_sent++;
      @(negedge clk);
      chk(in_ready == 1'b0, "R8", "in_ready after accept", 64'(in_ready), 64'd0);
      in_valid = 1'b0;
   endtask

   initial begin : drv
      in_valid = 1'b0;
      in_word  = '0;
      wait (rst_n);
      @(negedge clk);
      chk(ser_data == 1'b0,   "R9", "ser_data after reset",   64'(ser_data),   64'd0);
      chk(word_start == 1'b0, "R9", "word_start after reset", 64'(word_start), 64'd0);
      chk(in_ready == 1'b1,   "R9", "in_ready after reset",   64'(in_ready),   64'd1);
      for (int i = 0; i < (1 << WL); i++) send(WL'(i), i > 0);
      for (int i = 0; i < 8; i++) begin
         for (int c = 0; c < 3*SL; c++) begin
            in_word = WL'(~(i*11 + c));
            @(negedge clk);
         end
         send(WL'(i*37 + 5), 1'b0);
      end
      while (n_done < n_sent) @(negedge clk);
      repeat (4*SL) @(negedge clk);
      chk(n_rise == n_sent, "R8", "words on line vs accepted", 64'(n_rise), 64'(n_sent));
      done = 1'b1;
   end

   initial begin : mon
      int slot, cyc, last_rise;
      logic prev_line, prev_stb, prev_lclk, pre_lvl, first;
      logic [SL-1:0] cap;
      slot = SL; cyc = 0; last_rise = 0;
      prev_line = 1'b0; prev_stb = 1'b0; prev_lclk = 1'b0; pre_lvl = 1'b0; first = 1'b1;
      cap = '0;
      wait (rst_n);
      forever begin
         @(negedge clk);
         cyc++;
         if (!first)
            chk(link_clk != prev_lclk, "R7", "link_clk toggle", 64'(link_clk), 64'(!prev_lclk));
         first = 1'b0;
         if (word_start && !prev_stb) begin
            chk(slot >= SL, "R3", "word cut short", 64'(slot), 64'(SL));
            if (n_rise < NW && b2b[n_rise])
               chk(cyc - last_rise == SL, "R3", "back-to-back spacing",
                   64'(cyc - last_rise), 64'(SL));
            chk(link_clk == 1'b1, "R7", "link_clk at slot 0", 64'(link_clk), 64'd1);
            last_rise = cyc;
            n_rise++;
            slot = 0;
            pre_lvl = prev_line;
         end
         if (slot < SL) begin
            cap[SL-1-slot] = ser_data;
            chk(word_start == (slot < 2), "R7", $sformatf("word_start slot %0d", slot),
                64'(word_start), 64'(slot < 2));
            slot++;
            if (slot == SL) begin
               if (n_done < n_sent) evaluate(n_done, pre_lvl, cap);
               n_done++;
            end
         end else begin
            chk(ser_data == prev_line, "R8", "idle line holds", 64'(ser_data), 64'(prev_line));
         end
         prev_line = ser_data;
         prev_stb  = word_start;
         prev_lclk = link_clk;
      end
   end
endmodule

module phase_inv_enc_tb_top;
   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   bit   timeout = 1'b0;

   always #2 clk = ~clk;

   phase_inv_enc_lane #(.WL(4), .STRICT(1'b0)) lane_a (.clk(clk), .rst_n(rst_n));
   phase_inv_enc_lane #(.WL(6), .STRICT(1'b1)) lane_b (.clk(clk), .rst_n(rst_n));

   initial begin : top
      int checks, errors;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      fork
         wait (lane_a.done && lane_b.done);
         begin
            repeat (100000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      disable fork;
      checks = lane_a.n_checks + lane_b.n_checks + 1;
      errors = lane_a.n_errs + lane_b.n_errs;
      if (timeout) begin
         errors++;
         $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule